// File: doc/BRIEF.md
# Dual-Compare Single and Repeating Pulse Generator

This block produces a pulse on one output pin from a running timer count. Two 16-bit up-counters serve as time bases; each counts while its enable is high and returns to zero on the cycle after it equals its period value. A control write selects one of the two counters and a pulse mode. After arming, the output rises when the selected count equals the primary compare value and falls when it equals the secondary compare value. The output is therefore high for a window whose start and end are set by the two compare values, measured from the timer's zero.

In the one-shot mode exactly one pulse is made per control write. A further one-shot is armed by writing the mode again, without stopping the timer. In the repeating mode a pulse is made in every timer period for as long as the mode stays set. Each trailing edge sets a sticky interrupt flag. The interrupt output is that flag masked by an enable input.

Top module: `dcp_pulse_top`

## Requirements
- R1: After reset the output, the interrupt flag and the interrupt output are 0, both timer counts are 0, and no pulse mode is armed.
- R2: A timer whose enable is 1 adds one to its count each clock, and after a clock edge where the count equals its period the count is 0. A timer whose enable is 0 holds its count.
- R3: Bit 3 of the control write value picks the time base that drives the comparisons: 0 picks timer 0 and 1 picks timer 1. The other timer has no effect on the output.
- R4: A control write (strobe high for one clock, value on bits [3:0]) drives the output low from the next cycle, whatever its state. Mode bits [2:0] = 3'b100 arm the one-shot mode and 3'b101 arm the repeating mode. Any other mode value leaves the output low with no pulses.
- R5: Once armed, the first clock edge where the selected, enabled timer equals the primary compare value drives the output high from the next cycle.
- R6: While the output is high, a clock edge where the selected, enabled timer equals the secondary compare value drives the output low from the next cycle and sets the interrupt flag.
- R7: In the one-shot mode no pulse follows the trailing edge until the control register is written again. Writing mode 3'b100 again arms a new pulse while the timer keeps running.
- R8: In the repeating mode one pulse is made per timer period, and the flag is set again at every trailing edge.
- R9: The interrupt flag stays 1 until the clear input is high at a clock edge without a trailing edge in the same cycle; a trailing edge wins over a clear. The interrupt output is 1 exactly when the flag and the interrupt enable are both 1.
- R10: If the period of the selected timer is below the secondary compare value, the trailing edge never comes: the output stays high and the flag stays 0.
- R11: A stopped timer gives no matches: while the selected timer's enable is 0 the output does not change, even if the count equals a compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 4 | Control write value: [2:0] mode, [3] timer select |
| priCmp | input | 16 | Primary compare value (leading edge) |
| secCmp | input | 16 | Secondary compare value (trailing edge) |
| tmrEn | input | 2 | Count enable, one bit per timer |
| tmrPeriod | input | 32 | Period values, timer 0 in [15:0], timer 1 in [31:16] |
| flagClr | input | 1 | Clears the interrupt flag |
| irqEn | input | 1 | Interrupt enable |
| pulseOut | output | 1 | Pulse output pin |
| irqFlag | output | 1 | Sticky interrupt flag |
| irqOut | output | 1 | Interrupt request, flag masked by enable |
| tmrCount | output | 32 | Timer counts, timer 0 in [15:0], timer 1 in [31:16] |

## Verification
The assertions check, on every cycle, the local rules: the timer wrap and hold, the forced low after a pulse-mode write, the rule that a rise needs a primary match in the cycle before, that a trailing edge leaves the flag set, the stickiness of the flag and the masking of the interrupt. What they cannot see is the order of events across many cycles. Only the bench scenarios show that a one-shot gives exactly one pulse until it is re-armed, that the repeating mode gives one pulse per period, that the unselected timer is ignored, and that a period below the secondary value leaves the output high for good.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  localparam int NUM_TMR = 2;
  localparam int CTRL_W  = 4;

  localparam logic [2:0] MODE_ONESHOT = 3'b100;
  localparam logic [2:0] MODE_REPEAT  = 3'b101;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_FALL = 2'd2,
    ST_DONE = 2'd3
  } pulse_state_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic drvHigh;
    logic drvLow;
    logic setFlag;
    logic tmrSel;
  } dcp_strobe_t;

endpackage

// File: rtl/dcp_timer.sv
module dcp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count
);

  logic atPeriod;

  assign atPeriod = (count == period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (en) begin
      if (atPeriod) count <= '0;
      else          count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/dcp_ctrl.sv
module dcp_ctrl
  import dcp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              priHit,
  input  logic              secHit,
  output dcp_strobe_t       stb
);

  pulse_state_e state, stateNxt;
  logic [2:0]   modeReg;
  logic         selReg;
  logic         wrPulseMode;
  logic         hiNxt, loNxt, flagNxt;

  assign wrPulseMode = (ctrlWdata[2:0] == MODE_ONESHOT) ||
                       (ctrlWdata[2:0] == MODE_REPEAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= 3'b000;
      selReg  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctrlWe) begin
        modeReg <= ctrlWdata[2:0];
        selReg  <= ctrlWdata[3];
      end
    end
  end

  always_comb begin
    stateNxt = state;
    hiNxt    = 1'b0;
    loNxt    = 1'b0;
    flagNxt  = 1'b0;
    if (ctrlWe) begin
      // a control write always parks the pin low; matches this cycle are dropped
      loNxt    = 1'b1;
      stateNxt = wrPulseMode ? ST_RISE : ST_IDLE;
    end else begin
      unique case (state)
        ST_RISE: begin
          if (priHit) begin
            hiNxt    = 1'b1;
            stateNxt = ST_FALL;
          end
        end
        ST_FALL: begin
          if (secHit) begin
            loNxt    = 1'b1;
            flagNxt  = 1'b1;
            stateNxt = (modeReg == MODE_REPEAT) ? ST_RISE : ST_DONE;
          end
        end
        default: stateNxt = state;
      endcase
    end
  end

  always_comb begin
    stb.drvHigh = hiNxt;
    stb.drvLow  = loNxt;
    stb.setFlag = flagNxt;
    stb.tmrSel  = selReg;
  end

endmodule

// File: rtl/dcp_datapath.sv
module dcp_datapath
  import dcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dcp_strobe_t                     stb,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   tmrCount,
  input  logic [NUM_TMR-1:0]              tmrEn,
  input  logic [CNT_W-1:0]                priCmp,
  input  logic [CNT_W-1:0]                secCmp,
  input  logic                            flagClr,
  input  logic                            irqEn,
  output logic                            priHit,
  output logic                            secHit,
  output logic                            pulseOut,
  output logic                            irqFlag,
  output logic                            irqOut
);

  logic [CNT_W-1:0] selCount;
  logic             selEn;

  assign selCount = tmrCount[stb.tmrSel];
  assign selEn    = tmrEn[stb.tmrSel];
  assign priHit   = selEn && (selCount == priCmp);
  assign secHit   = selEn && (selCount == secCmp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOut <= 1'b0;
    end else if (stb.drvLow) begin
      pulseOut <= 1'b0;
    end else if (stb.drvHigh) begin
      pulseOut <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (stb.setFlag) begin
      irqFlag <= 1'b1;
    end else if (flagClr) begin
      irqFlag <= 1'b0;
    end
  end

  assign irqOut = irqFlag & irqEn;

endmodule

// File: rtl/dcp_pulse_top.sv
module dcp_pulse_top
  import dcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ctrlWe,
  input  logic [CTRL_W-1:0]             ctrlWdata,
  input  logic [CNT_W-1:0]              priCmp,
  input  logic [CNT_W-1:0]              secCmp,
  input  logic [NUM_TMR-1:0]            tmrEn,
  input  logic [NUM_TMR-1:0][CNT_W-1:0] tmrPeriod,
  input  logic                          flagClr,
  input  logic                          irqEn,
  output logic                          pulseOut,
  output logic                          irqFlag,
  output logic                          irqOut,
  output logic [NUM_TMR-1:0][CNT_W-1:0] tmrCount
);

  dcp_strobe_t stb;
  logic        priHit, secHit;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    dcp_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rstN   (rstN),
      .en     (tmrEn[t]),
      .period (tmrPeriod[t]),
      .count  (tmrCount[t])
    );
  end

  dcp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .priHit    (priHit),
    .secHit    (secHit),
    .stb       (stb)
  );

  dcp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .tmrCount (tmrCount),
    .tmrEn    (tmrEn),
    .priCmp   (priCmp),
    .secCmp   (secCmp),
    .flagClr  (flagClr),
    .irqEn    (irqEn),
    .priHit   (priHit),
    .secHit   (secHit),
    .pulseOut (pulseOut),
    .irqFlag  (irqFlag),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker
  import dcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          ctrlWe,
  input logic [CTRL_W-1:0]             ctrlWdata,
  input logic [CNT_W-1:0]              priCmp,
  input logic [NUM_TMR-1:0]            tmrEn,
  input logic [NUM_TMR-1:0][CNT_W-1:0] tmrPeriod,
  input logic                          flagClr,
  input logic                          irqEn,
  input logic                          pulseOut,
  input logic                          irqFlag,
  input logic                          irqOut,
  input logic [NUM_TMR-1:0][CNT_W-1:0] tmrCount
);

  // R2: wrap to zero after the period value
  p_timer_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tmrEn[0] && tmrCount[0] == tmrPeriod[0]) |=> (tmrCount[0] == '0));

  // R2: a disabled timer holds
  p_timer_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tmrEn[1] |=> $stable(tmrCount[1]));

  // R4: a pulse-mode write forces the pin low next cycle
  p_arm_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata[2:1] == 2'b10) |=> !pulseOut);

  // R5: a rise needs a primary match on some timer in the cycle before
  p_rise_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> $past(tmrCount[0] == priCmp || tmrCount[1] == priCmp));

  // R6: a trailing edge not caused by a write leaves the flag set
  p_fall_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pulseOut) && !$past(ctrlWe)) |-> irqFlag);

  // R9: flag stays set without a clear
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);

  // R9: masked interrupt
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);

endmodule

bind dcp_pulse_top dcp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlWe    (ctrlWe),
  .ctrlWdata (ctrlWdata),
  .priCmp    (priCmp),
  .tmrEn     (tmrEn),
  .tmrPeriod (tmrPeriod),
  .flagClr   (flagClr),
  .irqEn     (irqEn),
  .pulseOut  (pulseOut),
  .irqFlag   (irqFlag),
  .irqOut    (irqOut),
  .tmrCount  (tmrCount)
);

// File: tb/sim_dcp_pulse_top.sv
`timescale 1ns/1ps
module sim_dcp_pulse_top;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ctrlWe = 1'b0;
  logic [3:0]       ctrlWdata = 4'h0;
  logic [15:0]      priCmp = 16'd0;
  logic [15:0]      secCmp = 16'd0;
  logic [1:0]       tmrEn = 2'b00;
  logic [1:0][15:0] tmrPeriod = '0;
  logic             flagClr = 1'b0;
  logic             irqEn = 1'b0;
  logic             pulseOut, irqFlag, irqOut;
  logic [1:0][15:0] tmrCount;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int falls = 0;
  int cycles = 0;
  logic prevOut = 1'b0;

  // bench-side expectation
  logic [15:0] mCnt [2];
  int          mState;   // 0 idle, 1 wait rise, 2 wait fall, 3 done
  logic [2:0]  mMode;
  logic        mSel;
  logic        mOut;
  logic        mFlag;

  always #5 clk = ~clk;

  dcp_pulse_top u0 (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .priCmp(priCmp), .secCmp(secCmp), .tmrEn(tmrEn), .tmrPeriod(tmrPeriod),
    .flagClr(flagClr), .irqEn(irqEn), .pulseOut(pulseOut), .irqFlag(irqFlag),
    .irqOut(irqOut), .tmrCount(tmrCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nextCount(input logic [15:0] c, input logic [15:0] p, input logic e);
    if (!e) return c;
    if (c == p) return 16'd0;
    return c + 16'd1;
  endfunction

  function automatic bit isPulseMode(input logic [2:0] m);
    return (m == 3'b100) || (m == 3'b101);
  endfunction

  task automatic modelReset();
    mCnt[0] = 0; mCnt[1] = 0; mState = 0; mMode = 0; mSel = 0; mOut = 0; mFlag = 0;
  endtask

  // one clock: update expectation at the edge, compare at the falling edge
  task automatic tick();
    logic [15:0] sc;
    logic        se, pHit, sHit, setF;
    @(posedge clk);
    sc   = mSel ? mCnt[1] : mCnt[0];
    se   = tmrEn[mSel];
    pHit = se && (sc == priCmp);
    sHit = se && (sc == secCmp);
    setF = 1'b0;
    if (ctrlWe) begin
      mMode = ctrlWdata[2:0];
      mSel  = ctrlWdata[3];
      mOut  = 1'b0;
      mState = isPulseMode(ctrlWdata[2:0]) ? 1 : 0;
    end else if (mState == 1 && pHit) begin
      mOut = 1'b1; mState = 2;
    end else if (mState == 2 && sHit) begin
      mOut = 1'b0; setF = 1'b1;
      mState = (mMode == 3'b101) ? 1 : 3;
    end
    if (setF) mFlag = 1'b1;
    else if (flagClr) mFlag = 1'b0;
    for (int t = 0; t < 2; t++) mCnt[t] = nextCount(mCnt[t], tmrPeriod[t], tmrEn[t]);
    @(negedge clk);
    check(pulseOut == mOut, "R5 output", int'(pulseOut), int'(mOut));
    check(irqFlag == mFlag, "R9 flag", int'(irqFlag), int'(mFlag));
    check(irqOut == (mFlag && irqEn), "R9 irq", int'(irqOut), int'(mFlag && irqEn));
    check(tmrCount[0] == mCnt[0], "R2 timer0", int'(tmrCount[0]), int'(mCnt[0]));
    check(tmrCount[1] == mCnt[1], "R2 timer1", int'(tmrCount[1]), int'(mCnt[1]));
    if (pulseOut && !prevOut) rises++;
    if (!pulseOut && prevOut) falls++;
    prevOut = pulseOut;
    ctrlWe  = 1'b0;
    flagClr = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  task automatic writeCtrl(input logic sel, input logic [2:0] mode);
    ctrlWe = 1'b1;
    ctrlWdata = {sel, mode};
    tick();
  endtask

  task automatic clearCounts();
    rises = 0; falls = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pulseOut == 1'b0, "R1 output", int'(pulseOut), 0);
    check(irqFlag == 1'b0, "R1 flag", int'(irqFlag), 0);
    check(irqOut == 1'b0, "R1 irq", int'(irqOut), 0);
    check(tmrCount == '0, "R1 timers", int'(tmrCount), 0);
    rstN = 1'b1;

    // R7: one-shot on timer 0
    tmrPeriod[0] = 16'd20; tmrPeriod[1] = 16'd30;
    priCmp = 16'd5; secCmp = 16'd10;
    tmrEn = 2'b01;
    run(3);
    // R2: timer 0 counted three times, timer 1 held
    check(tmrCount[0] == 16'd3, "R2 count", int'(tmrCount[0]), 3);
    check(tmrCount[1] == 16'd0, "R2 hold", int'(tmrCount[1]), 0);
    clearCounts();
    writeCtrl(1'b0, 3'b100);
    run(100);
    check(rises == 1, "R7 single pulse", rises, 1);
    check(falls == 1, "R6 trailing edge", falls, 1);
    check(irqFlag == 1'b1, "R6 flag set", int'(irqFlag), 1);
    check(irqOut == 1'b0, "R9 masked", int'(irqOut), 0);
    irqEn = 1'b1;
    tick();
    check(irqOut == 1'b1, "R9 unmasked", int'(irqOut), 1);
    flagClr = 1'b1;
    tick();
    check(irqFlag == 1'b0, "R9 clear", int'(irqFlag), 0);
    run(40);
    check(irqFlag == 1'b0, "R7 no further trailing edge", int'(irqFlag), 0);

    // R7: re-arm with timer running
    clearCounts();
    writeCtrl(1'b0, 3'b100);
    run(100);
    check(rises == 1, "R7 rearm pulse", rises, 1);

    // R8: repeating mode, 10 periods of 21 cycles
    clearCounts();
    writeCtrl(1'b0, 3'b101);
    run(210);
    check(rises == 10, "R8 pulses per period", rises, 10);
    flagClr = 1'b1;
    tick();
    run(21);
    check(irqFlag == 1'b1, "R8 flag set again", int'(irqFlag), 1);

    // R4: write with idle mode while high
    while (!pulseOut) tick();
    clearCounts();
    writeCtrl(1'b0, 3'b000);
    check(pulseOut == 1'b0, "R4 forced low", int'(pulseOut), 0);
    run(60);
    check(rises == 0, "R4 idle mode no pulse", rises, 0);

    // R3 / R11: timer 1 selected and stopped at 0, timer 0 keeps matching
    priCmp = 16'd0; secCmp = 16'd4;
    clearCounts();
    writeCtrl(1'b1, 3'b101);
    run(60);
    check(rises == 0, "R11 stopped timer no match", rises, 0);
    check(pulseOut == 1'b0, "R3 other timer ignored", int'(pulseOut), 0);
    tmrEn = 2'b11;
    run(62);
    check(rises == 2, "R3 selected timer drives", rises, 2);

    // R10: period below secondary value
    tmrEn = 2'b01;
    tmrPeriod[0] = 16'd8; priCmp = 16'd3; secCmp = 16'd12;
    flagClr = 1'b1;
    tick();
    clearCounts();
    writeCtrl(1'b0, 3'b101);
    run(100);
    check(pulseOut == 1'b1, "R10 stays high", int'(pulseOut), 1);
    check(falls == 0, "R10 no trailing edge", falls, 0);
    check(irqFlag == 1'b0, "R10 flag clear", int'(irqFlag), 0);

    // R9: set wins over clear in the same cycle
    secCmp = 16'd6;
    while (!(tmrCount[0] == 16'd6)) tick();
    flagClr = 1'b1;
    tick();
    check(irqFlag == 1'b1, "R9 set beats clear", int'(irqFlag), 1);

    // constrained random phase
    tmrPeriod[0] = 16'd40; tmrPeriod[1] = 16'd33;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(39) == 0) begin
        ctrlWe = 1'b1;
        ctrlWdata = {1'($urandom_range(1)),
                     ($urandom_range(3) == 0) ? 3'($urandom_range(7)) :
                     ($urandom_range(1) ? 3'b100 : 3'b101)};
      end
      if ($urandom_range(15) == 0) flagClr = 1'b1;
      if ($urandom_range(31) == 0) irqEn = ~irqEn;
      if ($urandom_range(49) == 0) tmrEn = 2'($urandom_range(3));
      if ($urandom_range(99) == 0) priCmp = 16'($urandom_range(40));
      if ($urandom_range(99) == 0) secCmp = 16'($urandom_range(40));
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule